// File: doc/BRIEF.md
# Timer Interrupt Router

This block sits behind a bank of event timers and turns each timer's fire and clear events into interrupt activity. Every timer carries its own enable, trigger type (level or edge), destination line number and message-delivery enable. A fire on an enabled timer, while the global enable is on, either raises a held level on the selected line and records it in the status vector, drives a single-clock pulse on that line, or queues one 32-bit memory write whose address and data come from the timer's 64-bit message route word.

A compatibility mode pins timer 0 to line 0 and timer 1 to a fixed clock-chip line, whatever their own route fields say. That same line normally mirrors an external real-time-clock interrupt input. The input is always sampled, but it only reaches the line while compatibility mode is off. Software clears level interrupts by writing ones to the status vector.

Top module: `tmr_irq_router`

## Requirements
- R1: With `legacy_en` high, timer 0 drives line 0 and timer 1 drives line `RTC_LINE` (default 8), regardless of their route fields.
- R2: Every other timer, and timers 0 and 1 while `legacy_en` is low, drives the line numbered by its own `RW`-bit route field. Timer i's field is `tmr_route[i*RW +: RW]`.
- R3: A fire on a timer whose enable is low, or while `glb_en` is low, acts as a clear. Its status bit goes to 0 and its line is released.
- R4: A level-type fire (`tmr_level` = 1) on a live timer sets its status bit and holds its line high from the next cycle until a clear event.
- R5: An edge-type fire (`tmr_level` = 0) drives the line high for exactly one clock and leaves the status bit at 0.
- R6: A fire with `tmr_msg_en` set drives no line and does not change the status bit. It produces exactly one write with `mw_addr` = bits 63:32 and `mw_data` = bits 31:0 of that timer's word in `msg_route` (`msg_route[i*64 +: 64]`). `mw_valid` rises two cycles after the fire, and valid, address and data hold steady until `mw_ready` is seen high.
- R7: The `rtc_in` level is registered every cycle. It appears on line `RTC_LINE` one cycle later, but only while `legacy_en` is low.
- R8: Raising `legacy_en` lowers line `RTC_LINE` in the same cycle. Dropping it restores the last stored `rtc_in` level, including changes that arrived while the mode was on.
- R9: A 0-to-1 change of a timer's `tmr_msg_en` clears that timer's pending status bit.
- R10: A status write (`sts_wr` with `sts_wdata`) clears only those bits that are 1 in both the data and the current status. Zeros in the data, and ones for bits already clear, have no effect.
- R11: When several message timers have writes pending, they are issued one per handshake, lowest timer index first.
- R12: After reset, all lines, the status vector and `mw_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glb_en | input | 1 | Global enable |
| legacy_en | input | 1 | Compatibility routing mode |
| tmr_en | input | NT | Per-timer enable |
| tmr_level | input | NT | 1 = level type, 0 = edge type |
| tmr_msg_en | input | NT | Per-timer message delivery select |
| tmr_route | input | NT*RW | Per-timer destination line numbers |
| msg_route | input | NT*64 | Per-timer message word, address in the upper half |
| fire | input | NT | Per-timer fire event strobe |
| clr | input | NT | Per-timer clear event strobe |
| sts_wr | input | 1 | Status write-one-to-clear strobe |
| sts_wdata | input | NT | Status write data |
| rtc_in | input | 1 | External real-time-clock interrupt level |
| mw_ready | input | 1 | Memory-write accept |
| irq_out | output | NL | Interrupt lines |
| irq_sts | output | NT | Per-timer level status |
| mw_valid | output | 1 | Memory-write request |
| mw_addr | output | 32 | Memory-write address |
| mw_data | output | 32 | Memory-write data |

## Verification
The bench targets the legacy override of timers 0 and 1. A router that ignores the mode would light the line named in the route field instead of line 0 or the clock-chip line. The clock-chip line is exercised across mode changes, with the input toggled while the mode is on. A design that forgot the stored level would stay low after release, and one that failed to mask the input would leak it through during the mode. Status writes are driven with zeros, with ones on already-clear bits and with ones on set bits, and fires arrive on disabled timers. A router that treated every write as a clear, or that accepted a disabled fire, would show a wrong status bit. Two message timers fire together against a stalled acceptor. This catches a lost second write, a reversed order, address and data swapped, or a request that moves before it is accepted.

// File: rtl/tmr_irq_router.sv
module tmr_irq_router #(
  parameter int NT       = 4,
  parameter int NL       = 16,
  parameter int RW       = 4,
  parameter int RTC_LINE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             glb_en,
  input  logic             legacy_en,
  input  logic [NT-1:0]    tmr_en,
  input  logic [NT-1:0]    tmr_level,
  input  logic [NT-1:0]    tmr_msg_en,
  input  logic [NT*RW-1:0] tmr_route,
  input  logic [NT*64-1:0] msg_route,
  input  logic [NT-1:0]    fire,
  input  logic [NT-1:0]    clr,
  input  logic             sts_wr,
  input  logic [NT-1:0]    sts_wdata,
  input  logic             rtc_in,
  input  logic             mw_ready,
  output logic [NL-1:0]    irq_out,
  output logic [NT-1:0]    irq_sts,
  output logic             mw_valid,
  output logic [31:0]      mw_addr,
  output logic [31:0]      mw_data
);
  logic [NT-1:0] sts_q, pulse_q, pend_q, msg_en_q;
  logic [NT-1:0] live, fire_ok, clr_ev, set_lvl, drop, set_pulse, msg_new, grant;
  logic          rtc_q, load;

  assign live      = tmr_en & {NT{glb_en}};
  assign fire_ok   = fire & live;
  assign clr_ev    = (fire & ~live) | clr | ({NT{sts_wr}} & sts_wdata & sts_q)
                   | (tmr_msg_en & ~msg_en_q);
  assign set_lvl   = fire_ok & ~clr_ev & ~tmr_msg_en & tmr_level;
  assign set_pulse = fire_ok & ~clr_ev & ~tmr_msg_en & ~tmr_level;
  assign drop      = clr_ev | set_pulse;
  assign msg_new   = fire_ok & ~clr_ev & tmr_msg_en;
  assign load      = (|pend_q) & (~mw_valid | mw_ready);
  assign irq_sts   = sts_q;

  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < NT; i++) begin
      if (pend_q[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    int dest;
    irq_out = '0;
    for (int i = 0; i < NT; i++) begin
      dest = int'(tmr_route[i*RW +: RW]);
      if (legacy_en && i == 0) dest = 0;
      if (legacy_en && i == 1) dest = RTC_LINE;
      for (int l = 0; l < NL; l++) begin
        if (dest == l && (sts_q[i] || pulse_q[i]) && !tmr_msg_en[i]) irq_out[l] = 1'b1;
      end
    end
    for (int l = 0; l < NL; l++) begin
      if (l == RTC_LINE && rtc_q && !legacy_en) irq_out[l] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q    <= '0;
      pulse_q  <= '0;
      pend_q   <= '0;
      msg_en_q <= '0;
      rtc_q    <= 1'b0;
      mw_valid <= 1'b0;
      mw_addr  <= '0;
      mw_data  <= '0;
    end else begin
      sts_q    <= (sts_q & ~drop) | set_lvl;
      pulse_q  <= set_pulse;
      msg_en_q <= tmr_msg_en;
      rtc_q    <= rtc_in;
      pend_q   <= (pend_q & ~(load ? grant : '0)) | msg_new;
      mw_valid <= load | (mw_valid & ~mw_ready);
      if (load) begin
        for (int i = 0; i < NT; i++) begin
          if (grant[i]) begin
            mw_addr <= msg_route[i*64+32 +: 32];
            mw_data <= msg_route[i*64 +: 32];
          end
        end
      end
    end
  end
endmodule

module tmr_irq_router_chk #(
  parameter int NT       = 4,
  parameter int NL       = 16,
  parameter int RW       = 4,
  parameter int RTC_LINE = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             glb_en,
  input logic [NT-1:0]    tmr_en,
  input logic [NT-1:0]    tmr_level,
  input logic [NT-1:0]    tmr_msg_en,
  input logic [NT-1:0]    fire,
  input logic [NT-1:0]    clr,
  input logic             sts_wr,
  input logic [NT-1:0]    sts_wdata,
  input logic             mw_ready,
  input logic [NT-1:0]    irq_sts,
  input logic             mw_valid,
  input logic [31:0]      mw_addr,
  input logic [31:0]      mw_data
);
  assert_mw_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid && !mw_ready |=> mw_valid && $stable(mw_addr) && $stable(mw_data));

  for (genvar i = 0; i < NT; i++) begin : g_t
    assert_level_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fire[i] && tmr_en[i] && glb_en && tmr_level[i] && !tmr_msg_en[i] && !clr[i] && !sts_wr
      |=> irq_sts[i]);
    assert_dead_fire_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fire[i] && !(tmr_en[i] && glb_en) |=> !irq_sts[i]);
    assert_edge_nosts_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fire[i] && tmr_en[i] && glb_en && !tmr_level[i] && !tmr_msg_en[i] |=> !irq_sts[i]);
    assert_zero_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_sts[i] && sts_wr && !sts_wdata[i] && !clr[i] && !fire[i] && !tmr_msg_en[i]
      |=> irq_sts[i]);
  end
endmodule

bind tmr_irq_router tmr_irq_router_chk #(.NT(NT), .NL(NL), .RW(RW), .RTC_LINE(RTC_LINE)) chk_i (.*);

// File: tb/tmr_irq_router_tb.sv
module tmr_irq_router_tb_top;
  localparam int NT = 4, NL = 16, RW = 4, RTC = 8;

  logic clk = 0, rst_n = 0;
  logic glb_en = 0, legacy_en = 0, sts_wr = 0, rtc_in = 0, mw_ready = 0;
  logic [NT-1:0] tmr_en = 0, tmr_level = 0, tmr_msg_en = 0, fire = 0, clr = 0, sts_wdata = 0;
  logic [NT*RW-1:0] tmr_route = 0;
  logic [NT*64-1:0] msg_route = 0;
  logic [NL-1:0] irq_out;
  logic [NT-1:0] irq_sts;
  logic mw_valid;
  logic [31:0] mw_addr, mw_data;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [NT-1:0] m_sts = 0, m_pulse = 0, m_msgp = 0;
  logic m_rtc = 0;

  always #2 clk = ~clk;

  tmr_irq_router #(.NT(NT), .NL(NL), .RW(RW), .RTC_LINE(RTC)) dut_i (.*);

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [NL-1:0] exp_lines();
    logic [NL-1:0] v = '0;
    for (int i = 0; i < NT; i++) begin
      int d = int'(tmr_route[i*RW +: RW]);
      if (legacy_en && i == 0) d = 0;
      if (legacy_en && i == 1) d = RTC;
      if ((m_sts[i] || m_pulse[i]) && !tmr_msg_en[i]) v[d] = 1'b1;
    end
    if (m_rtc && !legacy_en) v[RTC] = 1'b1;
    return v;
  endfunction

  task automatic tick();
    logic [NT-1:0] ns, np;
    @(posedge clk);
    #1;
    ns = m_sts; np = '0;
    for (int i = 0; i < NT; i++) begin
      logic lv, ce;
      lv = tmr_en[i] && glb_en;
      ce = (fire[i] && !lv) || clr[i] || (sts_wr && sts_wdata[i] && m_sts[i])
           || (tmr_msg_en[i] && !m_msgp[i]);
      if (ce) ns[i] = 1'b0;
      else if (fire[i] && lv && !tmr_msg_en[i]) begin
        if (tmr_level[i]) ns[i] = 1'b1;
        else begin ns[i] = 1'b0; np[i] = 1'b1; end
      end
    end
    m_sts = ns; m_pulse = np; m_msgp = tmr_msg_en; m_rtc = rtc_in;
    check("R4/R5/R3 status model", 64'(irq_sts), 64'(m_sts));
    check("R1/R2/R7 line model", 64'(irq_out), 64'(exp_lines()));
    fire = 0; clr = 0; sts_wr = 0; sts_wdata = 0;
  endtask

  task automatic set_route(int i, int v);
    tmr_route[i*RW +: RW] = RW'(v);
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5EED));
    repeat (3) @(posedge clk);
    #1;
    check("R12 lines after reset", 64'(irq_out), 64'd0);
    check("R12 status after reset", 64'(irq_sts), 64'd0);
    check("R12 mw_valid after reset", 64'(mw_valid), 64'd0);
    rst_n = 1;
    glb_en = 1;

    // R1: legacy routing
    legacy_en = 1; tmr_en = 4'b1111; tmr_level = 4'b1011;
    set_route(0, 5); set_route(1, 3); set_route(2, 6); set_route(3, 7);
    fire = 4'b0001; tick();
    check("R1 timer0 on line 0", 64'(irq_out[0]), 64'd1);
    check("R1 timer0 not on own route", 64'(irq_out[5]), 64'd0);
    fire = 4'b0010; tick();
    check("R1 timer1 on rtc line", 64'(irq_out[RTC]), 64'd1);
    check("R1 timer1 not on own route", 64'(irq_out[3]), 64'd0);

    // R2: legacy off uses route fields
    legacy_en = 0; tick();
    check("R2 timer0 on route 5", 64'(irq_out[5]), 64'd1);
    check("R2 timer1 on route 3", 64'(irq_out[3]), 64'd1);
    check("R2 line 0 released", 64'(irq_out[0]), 64'd0);

    // R3: fire with global enable off acts as clear
    glb_en = 0; fire = 4'b0001; tick();
    check("R3 dead fire clears", 64'(irq_sts), 64'b0010);
    check("R3 line released", 64'(irq_out[5]), 64'd0);
    glb_en = 1;
    tmr_en[1] = 0; fire = 4'b0010; tick();
    check("R3 disabled timer fire clears", 64'(irq_sts), 64'd0);
    tmr_en[1] = 1;

    // R10: status write semantics
    fire = 4'b0011; tick();
    check("R4 both level set", 64'(irq_sts), 64'b0011);
    sts_wr = 1; sts_wdata = 4'b0000; tick();
    check("R10 zero write no effect", 64'(irq_sts), 64'b0011);
    sts_wr = 1; sts_wdata = 4'b0100; tick();
    check("R10 write to clear bit no effect", 64'(irq_sts), 64'b0011);
    sts_wr = 1; sts_wdata = 4'b0001; tick();
    check("R10 write one clears", 64'(irq_sts), 64'b0010);
    check("R10 line 3 still held", 64'(irq_out[3]), 64'd1);
    sts_wr = 1; sts_wdata = 4'b0010; tick();

    // R5: edge pulse
    fire = 4'b0100; tick();
    check("R5 pulse high", 64'(irq_out[6]), 64'd1);
    check("R5 status stays clear", 64'(irq_sts[2]), 64'd0);
    tick();
    check("R5 pulse one clock", 64'(irq_out[6]), 64'd0);

    // R7 / R8: rtc pass-through and legacy masking
    rtc_in = 1; tick();
    check("R7 rtc passes", 64'(irq_out[RTC]), 64'd1);
    legacy_en = 1; tick();
    check("R8 legacy lowers rtc line", 64'(irq_out[RTC]), 64'd0);
    rtc_in = 0; tick(); rtc_in = 1; tick();
    check("R7 rtc masked in legacy", 64'(irq_out[RTC]), 64'd0);
    legacy_en = 0; tick();
    check("R8 restore stored rtc level", 64'(irq_out[RTC]), 64'd1);
    rtc_in = 0; tick();

    // R9: msg enable rising clears status
    fire = 4'b1000; tick();
    check("R4 timer3 level set", 64'(irq_sts[3]), 64'd1);
    tmr_msg_en[3] = 1; tick();
    check("R9 msg enable clears status", 64'(irq_sts[3]), 64'd0);
    check("R9 line released", 64'(irq_out[7]), 64'd0);

    // R6 / R11: message writes
    tmr_msg_en[2] = 1;
    msg_route[2*64 +: 64] = 64'hA000_2222_D000_0002;
    msg_route[3*64 +: 64] = 64'hA000_3333_D000_0003;
    tick();
    fire = 4'b1100; tick();
    check("R6 no request yet", 64'(mw_valid), 64'd0);
    check("R6 no line driven", 64'(irq_out[7:6]), 64'd0);
    tick();
    check("R6 request raised", 64'(mw_valid), 64'd1);
    check("R11 lowest first addr", 64'(mw_addr), 64'hA000_2222);
    check("R6 data lower half", 64'(mw_data), 64'hD000_0002);
    tick(); tick();
    check("R6 held while stalled", 64'({mw_valid, mw_addr}), {31'd0, 1'b1, 32'hA000_2222});
    mw_ready = 1; tick();
    check("R11 second write follows", 64'({mw_valid, mw_addr}), {31'd0, 1'b1, 32'hA000_3333});
    check("R11 second data", 64'(mw_data), 64'hD000_0003);
    tick();
    check("R6 idle after two writes", 64'(mw_valid), 64'd0);
    tick(); tick();
    check("R6 single write each", 64'(mw_valid), 64'd0);
    mw_ready = 0;
    tmr_msg_en = 0; tick();

    // random phase (R2, R3, R4, R5, R7, R10)
    for (int n = 0; n < 400; n++) begin
      glb_en    = ($urandom % 8) != 0;
      tmr_en    = NT'($urandom);
      tmr_level = NT'($urandom);
      fire      = NT'($urandom);
      clr       = (($urandom % 6) == 0) ? NT'($urandom) : '0;
      sts_wr    = ($urandom % 5) == 0;
      sts_wdata = NT'($urandom);
      rtc_in    = $urandom % 2;
      if (($urandom % 10) == 0) legacy_en = ~legacy_en;
      if (($urandom % 4) == 0) tmr_route = (NT*RW)'($urandom);
      tick();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule